// File: doc/BRIEF.md
# Two-Master Shared Bus Handover Controller

This block decides which of two bus-master CPUs may drive a shared address and data bus. Each CPU has an active-low "get off the bus" request input and an active-low "I am off the bus" acknowledge output. The controller drives both request lines and watches both acknowledge lines. A host asks for ownership to move by pulsing a switch request together with the number of the CPU that should own the bus next.

Ownership moves break-before-make. The current owner is first told to yield. The controller then waits, under a cycle-counted timeout, until that owner reports that it has let go of the bus. Only then is the other CPU allowed to run. A yielding CPU only acknowledges at the end of its current machine cycle, which can take several of its clocks, so the wait has to tolerate that latency. While the bus has no driver, a gap flag tells the surrounding bus logic not to start any transfer. A grant ends with a one-cycle done pulse. A missed acknowledge ends with a one-cycle error pulse, and the old owner is put back on the bus.

Top module: `dual_bus_arbiter`

## Requirements
- R1: After synchronous reset, `owner` is 0 (CPU1) and `busrq_n` is 2'b01 (bit 0 is CPU1 and is high, bit 1 is CPU2 and is low). `busy` and `bus_gap` stay high until CPU2's acknowledge `busak_n[1]` is seen low, then both fall.
- R2: Each acknowledge input passes through a two-flop synchroniser. A level presented before clock edge a is acted on at edge a+2.
- R3: A switch request whose `sw_target` (0 = CPU1, 1 = CPU2) equals `owner` while idle gives `done` high for the one cycle after the sampling edge. `owner`, `busrq_n`, `busy` and `bus_gap` do not change.
- R4: A switch to the other CPU drives the current owner's request low at the edge that samples the request, and keeps the new CPU's request low. `busrq_n` is never 2'b11.
- R5: If the old owner's synchronised acknowledge is low at an edge where the wait counter has not yet passed its last value, that edge drives the new CPU's request high, sets `owner` to the new CPU, and raises `done` for one cycle.
- R6: If no acknowledge is seen, `err` rises exactly TIMEOUT_CYC edges after the sampling edge. At that edge the old owner's request returns high, the new CPU's request stays low and `owner` is unchanged. An acknowledge seen at that same edge wins over the timeout.
- R7: `bus_gap` and `busy` are high from the edge that accepts a switch until the edge of the grant or error, and low after it. Whenever both requests are low, `bus_gap` is high.
- R8: `owner` changes only on an edge that raises `done`.
- R9: A switch request that arrives while `busy` is high is ignored. The handover in progress finishes at the same edge and with the same result as without it.
- R10: `done` and `err` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_req | input | 1 | One-cycle switch request pulse |
| sw_target | input | 1 | CPU to own the bus next (0 = CPU1, 1 = CPU2) |
| busak_n | input | 2 | Active-low acknowledges from CPU1 (bit 0) and CPU2 (bit 1), asynchronous |
| busrq_n | output | 2 | Active-low yield requests to CPU1 (bit 0) and CPU2 (bit 1) |
| owner | output | 1 | CPU that currently owns the bus |
| busy | output | 1 | Initial settle or handover in progress |
| done | output | 1 | One-cycle pulse on grant or same-owner request |
| err | output | 1 | One-cycle pulse on acknowledge timeout |
| bus_gap | output | 1 | No master is allowed to drive the bus |

## Verification
The bench builds the block with TIMEOUT_CYC set to 16 and the synchroniser depth left at two. The short window makes both sides of the timeout boundary reachable in a few cycles. An acknowledge latency of TIMEOUT_CYC-3 grants on the final allowed edge, and one cycle more turns into an error on that same edge. Random latencies spread across the whole window sit alongside directed cases: an acknowledge that never comes, a request to the current owner, and a request injected while a handover is running.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_WAIT = 2'd2
  } arb_state_e;

  localparam int unsigned NUM_MASTERS = 2;
endpackage

// File: rtl/arb_ack_sync.sv
module arb_ack_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/arb_timer.sv
module arb_timer #(
  parameter int unsigned LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic last
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run && (cnt != LAST_VAL)) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_req,
  input  logic       sw_target,
  input  logic [1:0] ack_n_s,
  input  logic       tmo_last,
  output logic       tmr_clr,
  output logic       tmr_run,
  output logic [1:0] busrq_n,
  output logic       owner,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       bus_gap
);
  arb_state_e st;
  logic       tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_INIT;
      owner   <= 1'b0;
      tgt_q   <= 1'b0;
      busrq_n <= 2'b01;
      busy    <= 1'b1;
      bus_gap <= 1'b1;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        ST_INIT: begin
          if (!ack_n_s[1]) begin
            st      <= ST_IDLE;
            busy    <= 1'b0;
            bus_gap <= 1'b0;
          end
        end
        ST_IDLE: begin
          if (sw_req) begin
            if (sw_target == owner) begin
              done <= 1'b1;
            end else begin
              busrq_n[owner] <= 1'b0;
              tgt_q          <= sw_target;
              busy           <= 1'b1;
              bus_gap        <= 1'b1;
              st             <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (!ack_n_s[owner]) begin
            busrq_n[tgt_q] <= 1'b1;
            owner          <= tgt_q;
            done           <= 1'b1;
            busy           <= 1'b0;
            bus_gap        <= 1'b0;
            st             <= ST_IDLE;
          end else if (tmo_last) begin
            busrq_n[owner] <= 1'b1;
            err            <= 1'b1;
            busy           <= 1'b0;
            bus_gap        <= 1'b0;
            st             <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign tmr_clr = (st != ST_WAIT);
  assign tmr_run = (st == ST_WAIT);
endmodule

// File: rtl/dual_bus_arbiter.sv
module dual_bus_arbiter #(
  parameter int unsigned TIMEOUT_CYC = 100000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_req,
  input  logic       sw_target,
  input  logic [1:0] busak_n,
  output logic [1:0] busrq_n,
  output logic       owner,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       bus_gap
);
  localparam int unsigned NM = arb_pkg::NUM_MASTERS;

  logic [NM-1:0] ack_s;
  logic          tmr_clr, tmr_run, tmr_last;

  arb_ack_sync #(.WIDTH(NM), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d_async(busak_n), .q_sync(ack_s)
  );

  arb_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .run(tmr_run), .last(tmr_last)
  );

  arb_fsm u_fsm (
    .clk(clk), .rst(rst), .sw_req(sw_req), .sw_target(sw_target),
    .ack_n_s(ack_s), .tmo_last(tmr_last), .tmr_clr(tmr_clr), .tmr_run(tmr_run),
    .busrq_n(busrq_n), .owner(owner), .busy(busy), .done(done), .err(err),
    .bus_gap(bus_gap)
  );
endmodule

// File: rtl/dual_bus_arbiter_chk.sv
module dual_bus_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic       sw_req,
  input logic       sw_target,
  input logic [1:0] busak_n,
  input logic [1:0] busrq_n,
  input logic       owner,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       bus_gap
);
  a_r4_never_both_released: assert property (@(posedge clk) disable iff (rst)
    busrq_n != 2'b11);

  a_r8_owner_moves_on_done: assert property (@(posedge clk) disable iff (rst)
    (owner != $past(owner)) |-> done);

  a_r5_cpu1_release_on_end: assert property (@(posedge clk) disable iff (rst)
    $rose(busrq_n[0]) |-> (done || err));

  a_r5_cpu2_release_on_end: assert property (@(posedge clk) disable iff (rst)
    $rose(busrq_n[1]) |-> (done || err));

  a_r7_gap_while_undriven: assert property (@(posedge clk) disable iff (rst)
    (busrq_n == 2'b00) |-> (bus_gap && busy));

  a_r6_err_restores_owner: assert property (@(posedge clk) disable iff (rst)
    err |-> (busrq_n == (owner ? 2'b10 : 2'b01)));

  a_r3_same_owner_noop: assert property (@(posedge clk) disable iff (rst)
    (sw_req && !busy && (sw_target == owner)) |=>
      (done && $stable(busrq_n) && $stable(owner) && !busy));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
endmodule

bind dual_bus_arbiter dual_bus_arbiter_chk u_chk (
  .clk(clk), .rst(rst), .sw_req(sw_req), .sw_target(sw_target),
  .busak_n(busak_n), .busrq_n(busrq_n), .owner(owner), .busy(busy),
  .done(done), .err(err), .bus_gap(bus_gap)
);

// File: tb/dual_bus_arbiter_test.sv
module dual_bus_arbiter_test;
  localparam int T = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_req = 1'b0;
  logic       sw_target = 1'b0;
  logic [1:0] busak_n = 2'b11;
  logic [1:0] busrq_n;
  logic       owner, busy, done, err, bus_gap;

  int checks = 0;
  int failures = 0;
  logic exp_owner = 1'b0;

  always #5 clk = ~clk;

  dual_bus_arbiter #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .sw_req(sw_req), .sw_target(sw_target),
    .busak_n(busak_n), .busrq_n(busrq_n), .owner(owner), .busy(busy),
    .done(done), .err(err), .bus_gap(bus_gap)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] rq_for(input logic own);
    return own ? 2'b10 : 2'b01;
  endfunction

  // Cycle index after the sampling edge at which grant or error shows up.
  function automatic int event_cycle(input int d);
    return (d <= T - 3) ? d + 3 : T;
  endfunction

  task automatic do_switch(input logic tgt, input int d, input bit inject);
    logic old = exp_owner;
    bit   ok  = (d <= T - 3);
    int   evj = event_cycle(d);
    @(negedge clk); sw_req = 1'b1; sw_target = tgt;
    @(posedge clk);
    @(negedge clk); sw_req = 1'b0;
    if (tgt == old) begin
      chk(done == 1'b1, "R3 done", done, 1);
      chk(busrq_n == rq_for(old) && owner == old, "R3 unchanged", {busrq_n, owner}, {rq_for(old), old});
      chk(!busy && !bus_gap, "R3 idle", {busy, bus_gap}, 0);
      @(negedge clk);
      chk(done == 1'b0, "R10 done width", done, 0);
      return;
    end
    for (int j = 0; j <= evj; j++) begin
      if (j > 0) @(negedge clk);
      if (j == 1 && inject) begin sw_req = 1'b1; sw_target = old; end
      if (j == 2 && inject) sw_req = 1'b0;
      if (j == d) busak_n[old] = 1'b0;
      if (j < evj) begin
        chk(busy && bus_gap, inject ? "R9 busy/gap" : "R7 busy/gap", {busy, bus_gap}, 2'b11);
        chk(busrq_n == 2'b00, "R4 both held", busrq_n, 0);
        chk(!done && !err && owner == old, "R8 no early owner", {done, err, owner}, {2'b00, old});
      end else if (ok) begin
        chk(done && !err, "R5 done", {done, err}, 2'b10);
        chk(owner == tgt, "R5 owner", owner, tgt);
        chk(busrq_n == rq_for(tgt), "R5 release", busrq_n, rq_for(tgt));
        chk(!busy && !bus_gap, "R7 end", {busy, bus_gap}, 0);
      end else begin
        chk(err && !done, "R6 err", {done, err}, 2'b01);
        chk(owner == old, "R6 owner kept", owner, old);
        chk(busrq_n == rq_for(old), "R6 resume", busrq_n, rq_for(old));
        chk(!busy && !bus_gap, "R7 end err", {busy, bus_gap}, 0);
      end
    end
    @(negedge clk);
    chk(!done && !err, "R10 pulse width", {done, err}, 0);
    if (ok) begin
      busak_n[tgt] = 1'b1;
      exp_owner = tgt;
    end else begin
      busak_n[old] = 1'b1;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(owner == 1'b0 && busrq_n == 2'b01, "R1 reset", {busrq_n, owner}, 3'b010);
    chk(busy && bus_gap, "R1 settling", {busy, bus_gap}, 2'b11);
    busak_n[1] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(busy == 1'b1, "R2 sync latency", busy, 1);
    @(posedge clk); @(negedge clk);
    chk(!busy && !bus_gap, "R1 settled", {busy, bus_gap}, 0);
    repeat (2) @(negedge clk);

    do_switch(1'b0, 0, 1'b0);       // same owner
    do_switch(1'b1, 0, 1'b0);       // fastest acknowledge
    do_switch(1'b0, T - 3, 1'b0);   // grant on final edge
    do_switch(1'b1, T - 2, 1'b0);   // one cycle late: error
    do_switch(1'b1, 1000, 1'b0);    // acknowledge never comes
    do_switch(1'b1, 4, 1'b1);       // request injected while busy
    do_switch(1'b0, 1000, 1'b1);    // injected during timeout

    for (int n = 0; n < 40; n++) begin
      logic tg = 1'($urandom_range(0, 1));
      int   dd = int'($urandom_range(0, T + 1));
      bit   ij = ($urandom_range(0, 3) == 0);
      do_switch(tg, dd, ij);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule